// File: doc/BRIEF.md
# Clause 22 MDIO Management Master

This block is a register-mapped master for the two-wire PHY management bus. It runs IEEE Clause 22 read and write frames. Software starts a transaction with a single write to a packed command/status word. That word holds the PHY address, the register address, the direction and the write data. While the frame is being shifted out, the same word shows a busy flag. When a read finishes, the word returns the read data and a read-valid flag.

Completion is also reported through a cause register. Any write to that register clears cause bits with zeros and leaves them unchanged with ones, so software clears only the done flag by writing the inverse of its mask. A mask register gates the cause bit onto the interrupt output, so a driver can either sleep on the interrupt or poll the busy bit. The management clock is the system clock divided by an even parameter `CLK_DIV`. The management clock stays low when the bus is idle.

Top module: `mdio_ctrl`

## Requirements
- R1: Writing offset 0x00 while idle starts a frame. Field layout: bits [15:0] write data, [20:16] PHY address, [25:21] register address, bit 26 direction (1 = read, 0 = write). Bit 28 of the same word reads 1 from the cycle after the write until the frame ends. Bits [25:16] read back the latched addresses.
- R2: The frame is shifted out MSB first, one bit per management clock period. It is 64 bits long: 32 ones, start `01`, opcode (`10` read, `01` write), PHY address, register address, a 2-bit turnaround, then 16 data bits. A write frame drives turnaround `10` and the data, with the output enabled for all 64 bits.
- R3: On a read, the master releases the line (`mdio_oe` = 0) from the first turnaround bit to the end of the frame. It shifts the 16 sampled data bits into bits [15:0] and sets bit 27 (read valid) when the sampled second turnaround bit is 0.
- R4: If the second turnaround bit of a read is sampled as 1, bit 27 stays 0 after the frame. Bit 27 is also 0 after a write frame.
- R5: A write to offset 0x00 while bit 28 is set is ignored. The frame on the wire and the latched fields are unchanged.
- R6: Bit 4 of the cause register at offset 0x7C becomes 1 at the end of every read or write frame.
- R7: A write to 0x7C clears bit 4 when the written bit 4 is 0 and leaves it unchanged when the written bit 4 is 1.
- R8: Bit 4 of the mask register at offset 0x80 is writable and readable. `irq` is 1 exactly when the cause bit 4 and the mask bit 4 are both 1.
- R9: `mdc` has a period of `CLK_DIV` system clocks with equal high and low halves, and is low while idle. `mdio_out` changes only after a falling edge of `mdc`, and input data is sampled at the rising edge.
- R10: After reset, all three registers read 0, `irq` is 0, `mdc` is 0 and `mdio_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr` (combinational) |
| mdc | output | 1 | Management clock to the PHYs |
| mdio_out | output | 1 | Management data driven by the master |
| mdio_oe | output | 1 | Output enable for `mdio_out`; 0 releases the line |
| mdio_in | input | 1 | Management data line as seen at the pad |
| irq | output | 1 | Done interrupt |

## Verification
The bench uses a bus responder that counts `mdc` falling edges. It captures all 64 line bits of each frame, so a misplaced field, a wrong opcode or a turnaround that is driven at the wrong time shows up as a wrong captured frame. A design that sampled the turnaround one bit early or late would return shifted data or a wrong valid flag, and a forced turnaround-1 read targets exactly that case. A command written during a busy frame must leave both the wire and the readback untouched; a design that accepts it would corrupt the frame in flight. The cause register is written with all ones and then with the inverted done mask, which catches a write-one-to-clear or write-anything-clears implementation.

// File: rtl/mdio_pkg.sv
`timescale 1ns/1ps
package mdio_pkg;
    localparam int CMD_OFS   = 'h00;
    localparam int CAUSE_OFS = 'h7C;
    localparam int MASK_OFS  = 'h80;
    localparam int DONE_BIT  = 4;
    localparam int OP_BIT    = 26;
    localparam int VALID_BIT = 27;
    localparam int BUSY_BIT  = 28;
    localparam int FRAME_LEN = 64;
    localparam int TA_FIRST  = 46;
    localparam int DATA_FIRST = 48;

    typedef struct packed {
        logic        rd;
        logic [4:0]  regad;
        logic [4:0]  phy;
        logic [15:0] data;
    } mdio_cmd_t;
endpackage

// File: rtl/mdio_clkdiv.sv
`timescale 1ns/1ps
module mdio_clkdiv #(
    parameter int CLK_DIV = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic rise_tick,
    output logic fall_tick
);
    localparam int HALF = CLK_DIV / 2;
    localparam int CW   = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          mdc;
    } div_t;

    div_t div_d, div_q;

    always_comb begin
        div_d     = div_q;
        rise_tick = run && (div_q.cnt == CW'(HALF - 1));
        fall_tick = run && (div_q.cnt == CW'(CLK_DIV - 1));
        if (!run) begin
            div_d = '0;
        end else begin
            div_d.cnt = fall_tick ? '0 : div_q.cnt + 1'b1;
            if (rise_tick) div_d.mdc = 1'b1;
            if (fall_tick) div_d.mdc = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    assign mdc = div_q.mdc;
endmodule

// File: rtl/mdio_frame_seq.sv
`timescale 1ns/1ps
module mdio_frame_seq
    import mdio_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  mdio_cmd_t   cmd,
    input  logic        rise_tick,
    input  logic        fall_tick,
    input  logic        mdio_in,
    output logic        busy,
    output logic        mdio_out,
    output logic        mdio_oe,
    output logic        done,
    output logic        rd_ok,
    output logic [15:0] rd_data
);
    localparam int IW = $clog2(FRAME_LEN);

    typedef struct packed {
        logic                 busy;
        logic [IW-1:0]        idx;
        logic [FRAME_LEN-1:0] sh;
        logic                 rd;
        logic                 ta_ok;
        logic [15:0]          rsh;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        done  = seq_q.busy && fall_tick && (seq_q.idx == IW'(FRAME_LEN - 1));
        if (!seq_q.busy) begin
            if (start) begin
                seq_d.busy  = 1'b1;
                seq_d.idx   = '0;
                seq_d.rd    = cmd.rd;
                seq_d.ta_ok = 1'b0;
                seq_d.rsh   = '0;
                seq_d.sh    = {32'hFFFF_FFFF, 2'b01,
                               cmd.rd ? 2'b10 : 2'b01,
                               cmd.phy, cmd.regad,
                               cmd.rd ? 2'b00 : 2'b10,
                               cmd.rd ? 16'h0000 : cmd.data};
            end
        end else begin
            if (rise_tick && seq_q.rd) begin
                if (seq_q.idx == IW'(TA_FIRST + 1))
                    seq_d.ta_ok = !mdio_in;
                if (seq_q.idx >= IW'(DATA_FIRST))
                    seq_d.rsh = {seq_q.rsh[14:0], mdio_in};
            end
            if (fall_tick) begin
                seq_d.sh  = {seq_q.sh[FRAME_LEN-2:0], 1'b0};
                seq_d.idx = seq_q.idx + 1'b1;
                if (done) seq_d.busy = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign busy     = seq_q.busy;
    assign mdio_out = seq_q.busy && seq_q.sh[FRAME_LEN-1];
    assign mdio_oe  = seq_q.busy && !(seq_q.rd && (seq_q.idx >= IW'(TA_FIRST)));
    assign rd_ok    = seq_q.rd && seq_q.ta_ok;
    assign rd_data  = seq_q.rsh;
endmodule

// File: rtl/mdio_ctrl.sv
`timescale 1ns/1ps
module mdio_ctrl
    import mdio_pkg::*;
#(
    parameter int CLK_DIV = 40,
    parameter int ADDR_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              mdc,
    output logic              mdio_out,
    output logic              mdio_oe,
    input  logic              mdio_in,
    output logic              irq
);
    typedef struct packed {
        mdio_cmd_t cmd;
        logic      valid;
        logic      cause_done;
        logic      mask_done;
    } regs_t;

    regs_t st_d, st_q;

    logic        seq_busy, seq_done, seq_rd_ok;
    logic [15:0] seq_rd_data;
    logic        rise_tick, fall_tick;
    logic        cmd_hit, cause_hit, mask_hit, start;
    mdio_cmd_t   new_cmd;
    wire         unused_wdata = ^{bus_wdata[31:27]};

    assign new_cmd = '{rd: bus_wdata[OP_BIT], regad: bus_wdata[25:21],
                       phy: bus_wdata[20:16], data: bus_wdata[15:0]};

    always_comb begin
        st_d      = st_q;
        cmd_hit   = bus_wr && (bus_addr == ADDR_W'(CMD_OFS));
        cause_hit = bus_wr && (bus_addr == ADDR_W'(CAUSE_OFS));
        mask_hit  = bus_wr && (bus_addr == ADDR_W'(MASK_OFS));
        start     = cmd_hit && !seq_busy;
        if (start) begin
            st_d.cmd   = new_cmd;
            st_d.valid = 1'b0;
        end
        if (seq_done) begin
            st_d.valid = seq_rd_ok;
            if (st_q.cmd.rd) st_d.cmd.data = seq_rd_data;
        end
        if (cause_hit) st_d.cause_done = st_q.cause_done & bus_wdata[DONE_BIT];
        if (seq_done)  st_d.cause_done = 1'b1;
        if (mask_hit)  st_d.mask_done  = bus_wdata[DONE_BIT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(CMD_OFS)) begin
            bus_rdata[15:0]      = st_q.cmd.data;
            bus_rdata[20:16]     = st_q.cmd.phy;
            bus_rdata[25:21]     = st_q.cmd.regad;
            bus_rdata[OP_BIT]    = st_q.cmd.rd;
            bus_rdata[VALID_BIT] = st_q.valid;
            bus_rdata[BUSY_BIT]  = seq_busy;
        end else if (bus_addr == ADDR_W'(CAUSE_OFS)) begin
            bus_rdata[DONE_BIT]  = st_q.cause_done;
        end else if (bus_addr == ADDR_W'(MASK_OFS)) begin
            bus_rdata[DONE_BIT]  = st_q.mask_done;
        end
    end

    assign irq = st_q.cause_done & st_q.mask_done;

    mdio_clkdiv #(.CLK_DIV(CLK_DIV)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (seq_busy),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    mdio_frame_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .cmd       (new_cmd),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick),
        .mdio_in   (mdio_in),
        .busy      (seq_busy),
        .mdio_out  (mdio_out),
        .mdio_oe   (mdio_oe),
        .done      (seq_done),
        .rd_ok     (seq_rd_ok),
        .rd_data   (seq_rd_data)
    );
endmodule

// File: rtl/mdio_ctrl_chk.sv
`timescale 1ns/1ps
module mdio_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       cmd_hit,
    input logic       busy,
    input logic       done,
    input logic       mdc,
    input logic       mdio_out,
    input logic       mdio_oe,
    input logic [4:0] cmd_phy,
    input logic [4:0] cmd_reg,
    input logic       cause_done,
    input logic       mask_done,
    input logic       irq
);
    a_r1_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);

    a_r2_preamble_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (mdio_oe && mdio_out));

    a_r5_cmd_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_hit) |=> ($stable(cmd_phy) && $stable(cmd_reg)));

    a_r6_cause_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> cause_done);

    a_r8_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_done |-> !irq);

    a_r9_idle_mdc_low: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc);

    a_r9_data_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc && $past(mdc)) |-> $stable(mdio_out));
endmodule

bind mdio_ctrl mdio_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .cmd_hit    (cmd_hit),
    .busy       (seq_busy),
    .done       (seq_done),
    .mdc        (mdc),
    .mdio_out   (mdio_out),
    .mdio_oe    (mdio_oe),
    .cmd_phy    (st_q.cmd.phy),
    .cmd_reg    (st_q.cmd.regad),
    .cause_done (st_q.cause_done),
    .mask_done  (st_q.mask_done),
    .irq        (irq)
);

// File: tb/mdio_ctrl_tb.sv
`timescale 1ns/1ps
module mdio_ctrl_tb;
    localparam int DIV = 8;
    localparam int NV  = 6;
    // vector: {rd, ta_bad, phy[4:0], reg[4:0], data[15:0]}
    localparam logic [27:0] VEC [NV] = '{
        {1'b0, 1'b0, 5'h01, 5'h00, 16'h1234},
        {1'b0, 1'b0, 5'h1F, 5'h1F, 16'hFFFF},
        {1'b0, 1'b0, 5'h00, 5'h00, 16'h0000},
        {1'b1, 1'b0, 5'h05, 5'h02, 16'hA5C3},
        {1'b1, 1'b0, 5'h1A, 5'h11, 16'h8001},
        {1'b1, 1'b1, 5'h03, 5'h04, 16'h7777}
    };

    logic        clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        mdc, mdio_out, mdio_oe, mdio_in, irq;

    always #5 clk = ~clk;

    mdio_ctrl #(.CLK_DIV(DIV), .ADDR_W(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
        .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in), .irq(irq)
    );

    // PHY responder
    int          fcnt = 0, rcnt = 0, oecnt = 0;
    logic        phy_drv = 1'b1, phy_bad = 1'b0;
    logic [15:0] phy_data = '0;
    logic [63:0] cap = '0;
    time         t_prev = 0, t_last = 0;

    assign mdio_in = mdio_oe ? mdio_out : phy_drv;

    always @(negedge mdc) begin
        fcnt = fcnt + 1;
        if (fcnt == 47) phy_drv = phy_bad;
        else if (fcnt >= 48 && fcnt <= 63) phy_drv = phy_data[63 - fcnt];
        else phy_drv = 1'b1;
    end

    always @(posedge mdc) begin
        cap    = {cap[62:0], mdio_oe ? mdio_out : phy_drv};
        rcnt   = rcnt + 1;
        if (mdio_oe) oecnt = oecnt + 1;
        t_prev = t_last;
        t_last = $time;
    end

    int checks = 0, fails = 0;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic start_cmd(input logic r, input logic [4:0] p, input logic [4:0] g,
                             input logic [15:0] d);
        @(negedge clk);
        fcnt = 0; rcnt = 0; oecnt = 0; cap = '0; phy_drv = 1'b1;
        wr(8'h00, {5'b0, r, g, p, d});
    endtask

    task automatic wait_idle(output bit ok);
        logic [31:0] v;
        ok = 1'b0;
        for (int i = 0; i < 2000; i++) begin
            rd(8'h00, v);
            if (!v[28]) begin ok = 1'b1; break; end
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    function automatic logic [63:0] exp_frame(input logic r, input logic bad,
                                              input logic [4:0] p, input logic [4:0] g,
                                              input logic [15:0] d);
        return {32'hFFFF_FFFF, 2'b01, r ? 2'b10 : 2'b01, p, g,
                r ? {1'b1, bad} : 2'b10, d};
    endfunction

    initial begin
        #2_000_000;
        checks++; fails++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        bit ok;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10: reset state
        rd(8'h00, v); chk("R10 cmd reset", v, 0);
        rd(8'h7C, v); chk("R10 cause reset", v, 0);
        rd(8'h80, v); chk("R10 mask reset", v, 0);
        chk("R10 irq/mdc/oe reset", {irq, mdc, mdio_oe}, 0);

        // R8: done with mask clear gives no irq; R6 cause set
        start_cmd(1'b0, 5'h09, 5'h0A, 16'h5A5A);
        wait_idle(ok); chk("R1 frame ends", ok, 1);
        rd(8'h7C, v); chk("R6 cause after write", v[4], 1);
        chk("R8 masked irq", irq, 0);

        // R7: write ones keeps, write inverted mask clears
        wr(8'h7C, 32'hFFFF_FFFF);
        rd(8'h7C, v); chk("R7 ones keep", v[4], 1);
        wr(8'h7C, ~32'h10);
        rd(8'h7C, v); chk("R7 zero clears", v[4], 0);

        // R8: enable mask
        wr(8'h80, 32'h10);
        rd(8'h80, v); chk("R8 mask readback", v, 32'h10);

        // vector table
        for (int i = 0; i < NV; i++) begin
            logic        r, bad;
            logic [4:0]  p, g;
            logic [15:0] d;
            {r, bad, p, g, d} = VEC[i];
            phy_bad  = bad;
            phy_data = d;
            start_cmd(r, p, g, r ? 16'h0000 : d);
            rd(8'h00, v);
            chk("R1 busy set", v[28], 1);
            chk("R1 fields", v[25:16], {g, p});
            wait_idle(ok); chk("R1 frame ends", ok, 1);
            chk("R2 frame bits", cap, exp_frame(r, bad, p, g, d));
            chk("R2 bit count", rcnt, 64);
            chk("R3 drive count", oecnt, r ? 46 : 64);
            rd(8'h00, v);
            if (r && !bad) begin
                chk("R3 read data", v[15:0], d);
                chk("R3 read valid", v[27], 1);
            end else if (r) begin
                chk("R4 bad turnaround", v[27], 0);
            end else begin
                chk("R4 write no valid", v[27], 0);
                chk("R1 write data kept", v[15:0], d);
            end
            rd(8'h7C, v); chk("R6 cause set", v[4], 1);
            chk("R8 irq on", irq, 1);
            wr(8'h7C, ~32'h10);
            chk("R8 irq off", irq, 0);
        end

        // R5: command during busy is ignored
        phy_bad = 1'b0;
        start_cmd(1'b0, 5'h02, 5'h03, 16'h0F0F);
        repeat (20) @(negedge clk);
        wr(8'h00, {5'b0, 1'b1, 5'h1C, 5'h15, 16'hBEEF});
        wait_idle(ok);
        chk("R5 frame unchanged", cap, exp_frame(1'b0, 1'b0, 5'h02, 5'h03, 16'h0F0F));
        rd(8'h00, v);
        chk("R5 fields unchanged", v[26:0], {1'b0, 5'h03, 5'h02, 16'h0F0F});

        // R9: mdc period and idle level
        chk("R9 mdc period", t_last - t_prev, DIV * 10);
        repeat (DIV) @(negedge clk);
        chk("R9 idle low", mdc, 0);

        finish_run();
    end
endmodule